// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block lets a host read a set of small, read-only configuration items through a register port. Items sit in two parallel banks: a shared bank and an architecture-local bank. The host first writes a 16-bit key to the selector. The key names one item and restarts that item's byte cursor at zero. The host then reads the data register. Each read takes the next 1 to 8 bytes of the item, packs them most-significant first, and fills the low end of the result with zeros when the item runs out partway through a read.

Item bytes and lengths are held in an internal table. A simple load interface writes one byte or one length per cycle. Reset leaves every item empty except entry 0 of the shared bank. That entry is preloaded with a 4-byte signature and is selected, so a host can probe the port straight after reset.

A parameter chooses between two access schemes. In the split scheme the selector and data sit at separate register addresses. In the combined scheme a single address is used, and the access width decides what the access does.

Top module: `cfg_item_port`

## Requirements
- R1: Every selector write returns the byte cursor to zero, including a write whose key is rejected.
- R2: Key bit 15 chooses the architecture-local bank (1) or the shared bank (0). Bits 13:0 give the entry index, and bit 14 is ignored. An index at or above FILE_FIRST+FILE_SLOTS (64 by default) makes the selection invalid.
- R3: A data read of N bytes (1 to 8) returns the next item bytes with the first byte in bits 8N-1:8N-8. The cursor advances by the number of bytes taken.
- R4: When the item ends partway through a read, the bytes taken sit at the top of the N-byte value and the rest is zero.
- R5: A data read returns zero and leaves the cursor unchanged when the selection is invalid, the item is empty, or the cursor is already at the item length.
- R6: Reset selects key 0 in the shared bank with the cursor at zero. Reading 4 bytes then returns SIGNATURE (default 32'h5AC3960F).
- R7: In the split scheme (acc_reg=1 is the selector, acc_reg=0 is data), the following all return zero and leave the cursor unchanged: a selector read, and a data read of width 0 or above 8. A data write is ignored.
- R8: In the combined scheme, a 2-byte write selects, a 1-byte read is a data read, a write of any other width is ignored, and a read of any other width returns zero without moving the cursor.
- R9: A length load above MAX_LEN is stored as MAX_LEN. A reloaded length takes effect for later reads.
- R10: rd_valid pulses for exactly the cycle after each read access and is low in every other cycle, including directly after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Host access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_reg | input | 1 | Split scheme only: 1 = selector, 0 = data |
| acc_size | input | 4 | Access width in bytes |
| acc_wdata | input | 16 | Write data (key) |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 64 | Read response, right-aligned N-byte value |
| ld_len_we | input | 1 | Load an item length |
| ld_byte_we | input | 1 | Load an item byte |
| ld_bank | input | 1 | Bank of the loaded item |
| ld_index | input | IDX_W | Entry index of the loaded item |
| ld_addr | input | LA_W | Byte position within the item |
| ld_len | input | 32 | Length value |
| ld_byte | input | 8 | Byte value |

## Verification
Several properties are checked by the inline assertions on every cycle: the cursor clearing after a select, an out-of-range key turning into an invalid selection, the cursor never stepping further than the access width, zero data with a frozen cursor for reads on an invalid selection, responses appearing only after reads, and length clamping at load. Byte order, right-side zero padding, bank choice through bit 15, the effect of the ignored key bit, and the width rules of both schemes can only be shown by the bench. Its scenarios compare whole read values across consecutive accesses.

// File: rtl/cfgp_pkg.sv
`timescale 1ns/1ps
package cfgp_pkg;

    localparam int              KEY_W    = 16;
    localparam int              ARCH_BIT = 15;
    localparam logic [15:0]     IDX_MASK = 16'h3FFF;
    localparam int              ACC_MAX  = 8;
    localparam int              OFF_W    = 32;

    typedef struct packed {
        logic        valid;
        logic        bank;
        logic [13:0] idx;
    } sel_t;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_SEL_WR,
        ACC_DATA_RD,
        ACC_ZERO_RD,
        ACC_IGNORE
    } acc_kind_e;

    // Split a raw key into bank, index and validity against the entry limit.
    function automatic sel_t decode_key(input logic [KEY_W-1:0] key,
                                        input int unsigned limit);
        sel_t            s;
        logic [KEY_W-1:0] m;
        m       = key & IDX_MASK;
        s.bank  = key[ARCH_BIT];
        s.idx   = m[13:0];
        s.valid = (32'(m) < limit);
        return s;
    endfunction

    // Cursor advance that sticks at all-ones instead of wrapping.
    function automatic logic [OFF_W-1:0] sat_add(input logic [OFF_W-1:0] a,
                                                 input logic [3:0] b);
        logic [OFF_W:0] s;
        s = {1'b0, a} + (OFF_W+1)'(b);
        return s[OFF_W] ? '1 : s[OFF_W-1:0];
    endfunction

endpackage

// File: rtl/cfgp_access_decode.sv
`timescale 1ns/1ps
module cfgp_access_decode
    import cfgp_pkg::*;
#(
    parameter bit COMBINED = 1'b0
) (
    input  logic      valid,
    input  logic      write,
    input  logic      reg_sel,
    input  logic [3:0] size,
    output acc_kind_e kind
);

    generate
        if (COMBINED) begin : g_comb
            logic unused_reg;
            assign unused_reg = reg_sel;
            always_comb begin
                kind = ACC_NONE;
                if (valid) begin
                    if (write) kind = (size == 4'd2) ? ACC_SEL_WR : ACC_IGNORE;
                    else       kind = (size == 4'd1) ? ACC_DATA_RD : ACC_ZERO_RD;
                end
            end
        end else begin : g_split
            always_comb begin
                kind = ACC_NONE;
                if (valid) begin
                    if (reg_sel)
                        kind = write ? ACC_SEL_WR : ACC_ZERO_RD;
                    else if (write)
                        kind = ACC_IGNORE;
                    else if (size >= 4'd1 && size <= 4'(ACC_MAX))
                        kind = ACC_DATA_RD;
                    else
                        kind = ACC_ZERO_RD;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cfgp_item_store.sv
`timescale 1ns/1ps
module cfgp_item_store
    import cfgp_pkg::*;
#(
    parameter int          ENTRIES   = 64,
    parameter int          MAX_LEN   = 8,
    parameter logic [31:0] SIGNATURE = 32'h5AC3960F,
    localparam int         IDX_W     = $clog2(ENTRIES),
    localparam int         LA_W      = $clog2(MAX_LEN)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ld_len_we,
    input  logic                     ld_byte_we,
    input  logic                     ld_bank,
    input  logic [IDX_W-1:0]         ld_index,
    input  logic [LA_W-1:0]          ld_addr,
    input  logic [31:0]              ld_len,
    input  logic [7:0]               ld_byte,
    input  logic                     rd_bank,
    input  logic [IDX_W-1:0]         rd_index,
    output logic [31:0]              rd_len,
    output logic [MAX_LEN-1:0][7:0]  rd_bytes
);

    localparam int SIG_LEN = 4;

    logic [7:0]  mem  [2][ENTRIES][MAX_LEN];
    logic [31:0] lens [2][ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 2; b++)
                for (int e = 0; e < ENTRIES; e++)
                    lens[b][e] <= '0;
            lens[0][0] <= 32'(SIG_LEN);
            for (int k = 0; k < SIG_LEN; k++)
                mem[0][0][k] <= SIGNATURE[8*(SIG_LEN-1-k) +: 8];
        end else begin
            if (ld_len_we)
                lens[ld_bank][ld_index] <= (ld_len > 32'(MAX_LEN)) ? 32'(MAX_LEN) : ld_len;
            if (ld_byte_we)
                mem[ld_bank][ld_index][ld_addr] <= ld_byte;
        end
    end

    always_comb begin
        rd_len = lens[rd_bank][rd_index];
        for (int k = 0; k < MAX_LEN; k++)
            rd_bytes[k] = mem[rd_bank][rd_index][k];
    end

    AST_LEN_CLAMPED: assert property (@(posedge clk) disable iff (rst)
        ld_len_we |=> (lens[$past(ld_bank)][$past(ld_index)] <= 32'(MAX_LEN))); // R9

endmodule

// File: rtl/cfgp_packer.sv
`timescale 1ns/1ps
module cfgp_packer
    import cfgp_pkg::*;
#(
    parameter int  MAX_LEN = 8,
    localparam int LA_W    = $clog2(MAX_LEN)
) (
    input  logic [MAX_LEN-1:0][7:0] bytes,
    input  logic [31:0]             len,
    input  logic [31:0]             off,
    input  logic [3:0]              size,
    output logic [63:0]             value,
    output logic [3:0]              take
);

    logic [31:0] avail;
    logic [31:0] pos;
    logic [3:0]  n;

    always_comb begin
        avail = (off < len) ? (len - off) : '0;
        n     = (size > 4'(ACC_MAX)) ? 4'(ACC_MAX) : size;
        take  = (avail < 32'(n)) ? avail[3:0] : n;
        value = '0;
        pos   = off;
        for (int j = 0; j < ACC_MAX; j++) begin
            pos = off + 32'(j);
            if (j < int'(take) && pos < 32'(MAX_LEN))
                value = value | (64'(bytes[pos[LA_W-1:0]]) << (8 * (int'(n) - 1 - j)));
        end
    end

endmodule

// File: rtl/cfg_item_port.sv
`timescale 1ns/1ps
module cfg_item_port
    import cfgp_pkg::*;
#(
    parameter int          FILE_FIRST = 32,
    parameter int          FILE_SLOTS = 32,
    parameter int          MAX_LEN    = 8,
    parameter bit          COMBINED   = 1'b0,
    parameter logic [31:0] SIGNATURE  = 32'h5AC3960F,
    localparam int         ENTRIES    = FILE_FIRST + FILE_SLOTS,
    localparam int         IDX_W      = $clog2(ENTRIES),
    localparam int         LA_W       = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             acc_reg,
    input  logic [3:0]       acc_size,
    input  logic [15:0]      acc_wdata,
    output logic             rd_valid,
    output logic [63:0]      rd_data,
    input  logic             ld_len_we,
    input  logic             ld_byte_we,
    input  logic             ld_bank,
    input  logic [IDX_W-1:0] ld_index,
    input  logic [LA_W-1:0]  ld_addr,
    input  logic [31:0]      ld_len,
    input  logic [7:0]       ld_byte
);

    acc_kind_e               kind;
    sel_t                    cur_sel;
    logic [OFF_W-1:0]        cur_off;
    logic [31:0]             item_len;
    logic [MAX_LEN-1:0][7:0] item_bytes;
    logic [63:0]             pk_value;
    logic [3:0]              pk_take;

    cfgp_access_decode #(.COMBINED(COMBINED)) u_dec (
        .valid   (acc_valid),
        .write   (acc_write),
        .reg_sel (acc_reg),
        .size    (acc_size),
        .kind    (kind)
    );

    cfgp_item_store #(.ENTRIES(ENTRIES), .MAX_LEN(MAX_LEN), .SIGNATURE(SIGNATURE)) u_store (
        .clk        (clk),
        .rst        (rst),
        .ld_len_we  (ld_len_we),
        .ld_byte_we (ld_byte_we),
        .ld_bank    (ld_bank),
        .ld_index   (ld_index),
        .ld_addr    (ld_addr),
        .ld_len     (ld_len),
        .ld_byte    (ld_byte),
        .rd_bank    (cur_sel.bank),
        .rd_index   (cur_sel.idx[IDX_W-1:0]),
        .rd_len     (item_len),
        .rd_bytes   (item_bytes)
    );

    cfgp_packer #(.MAX_LEN(MAX_LEN)) u_pack (
        .bytes (item_bytes),
        .len   (item_len),
        .off   (cur_off),
        .size  (acc_size),
        .value (pk_value),
        .take  (pk_take)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_sel  <= decode_key(16'h0000, ENTRIES);
            cur_off  <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (kind == ACC_DATA_RD) || (kind == ACC_ZERO_RD);
            rd_data  <= '0;
            case (kind)
                ACC_SEL_WR: begin
                    cur_sel <= decode_key(acc_wdata, ENTRIES);
                    cur_off <= '0;
                end
                ACC_DATA_RD: begin
                    if (cur_sel.valid) begin
                        rd_data <= pk_value;
                        cur_off <= sat_add(cur_off, pk_take);
                    end
                end
                default: ;
            endcase
        end
    end

    AST_SEL_CLEARS_OFF: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_SEL_WR) |=> (cur_off == '0)); // R1

    AST_BAD_KEY_INVALID: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_SEL_WR && 32'(acc_wdata & IDX_MASK) >= 32'(ENTRIES)) |=> !cur_sel.valid); // R2

    AST_OFF_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_DATA_RD) |=> ((cur_off - $past(cur_off)) <= 32'($past(acc_size)))); // R3

    AST_INVALID_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_DATA_RD && !cur_sel.valid) |=> (rd_data == '0 && $stable(cur_off))); // R5

    AST_RESET_SELECTS_SIG: assert property (@(posedge clk)
        rst |=> (cur_sel.valid && !cur_sel.bank && cur_sel.idx == '0 && cur_off == '0)); // R6

    AST_REJECTED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_ZERO_RD) |=> (rd_valid && rd_data == '0 && $stable(cur_off))); // R7

    AST_RESP_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !(kind == ACC_DATA_RD || kind == ACC_ZERO_RD) |=> !rd_valid); // R10

endmodule

// File: tb/test_cfg_item_port.sv
`timescale 1ns/1ps
module test_cfg_item_port;

    typedef struct {
        logic [63:0] v;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    exp_t qa[$];
    exp_t qb[$];
    exp_t ea;
    exp_t eb;

    // Instance A: split scheme; instance B: combined scheme.
    logic        a_valid = 0, a_write = 0, a_reg = 0;
    logic [3:0]  a_size = 0;
    logic [15:0] a_wdata = 0;
    logic        a_rv;
    logic [63:0] a_rd;
    logic        a_llw = 0, a_lbw = 0, a_lbank = 0;
    logic [5:0]  a_lidx = 0;
    logic [2:0]  a_laddr = 0;
    logic [31:0] a_llen = 0;
    logic [7:0]  a_lbyte = 0;

    logic        b_valid = 0, b_write = 0;
    logic [3:0]  b_size = 0;
    logic [15:0] b_wdata = 0;
    logic        b_rv;
    logic [63:0] b_rd;
    logic        b_llw = 0, b_lbw = 0, b_lbank = 0;
    logic [5:0]  b_lidx = 0;
    logic [2:0]  b_laddr = 0;
    logic [31:0] b_llen = 0;
    logic [7:0]  b_lbyte = 0;

    cfg_item_port i_cfg_item_port (
        .clk(clk), .rst(rst),
        .acc_valid(a_valid), .acc_write(a_write), .acc_reg(a_reg),
        .acc_size(a_size), .acc_wdata(a_wdata),
        .rd_valid(a_rv), .rd_data(a_rd),
        .ld_len_we(a_llw), .ld_byte_we(a_lbw), .ld_bank(a_lbank),
        .ld_index(a_lidx), .ld_addr(a_laddr), .ld_len(a_llen), .ld_byte(a_lbyte)
    );

    cfg_item_port #(.COMBINED(1'b1)) i_cfg_item_port_comb (
        .clk(clk), .rst(rst),
        .acc_valid(b_valid), .acc_write(b_write), .acc_reg(1'b0),
        .acc_size(b_size), .acc_wdata(b_wdata),
        .rd_valid(b_rv), .rd_data(b_rd),
        .ld_len_we(b_llw), .ld_byte_we(b_lbw), .ld_bank(b_lbank),
        .ld_index(b_lidx), .ld_addr(b_laddr), .ld_len(b_llen), .ld_byte(b_lbyte)
    );

    // Monitors: pop the expected value for every response and compare.
    always @(negedge clk) begin
        if (!rst && a_rv) begin
            checks++;
            if (qa.size() == 0) begin
                errors++;
                $display("FAIL R10 split: response without read, actual=%h expected=none", a_rd);
            end else begin
                ea = qa.pop_front();
                if (a_rd !== ea.v) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", ea.tag, a_rd, ea.v);
                end
            end
        end
        if (!rst && b_rv) begin
            checks++;
            if (qb.size() == 0) begin
                errors++;
                $display("FAIL R10 combined: response without read, actual=%h expected=none", b_rd);
            end else begin
                eb = qb.pop_front();
                if (b_rd !== eb.v) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", eb.tag, b_rd, eb.v);
                end
            end
        end
    end

    task automatic access(input bit to_b, input bit wr, input bit rg, input logic [3:0] sz,
                          input logic [15:0] wd, input logic [63:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        e.v = exp;
        e.tag = tag;
        if (to_b) begin
            b_valid = 1; b_write = wr; b_size = sz; b_wdata = wd;
            if (!wr) qb.push_back(e);
        end else begin
            a_valid = 1; a_write = wr; a_reg = rg; a_size = sz; a_wdata = wd;
            if (!wr) qa.push_back(e);
        end
        @(negedge clk);
        a_valid = 0;
        b_valid = 0;
    endtask

    task automatic sel(input bit to_b, input logic [15:0] key);
        access(to_b, 1'b1, 1'b1, 4'd2, key, '0, "");
    endtask

    task automatic rd(input bit to_b, input logic [3:0] sz, input logic [63:0] exp, input string tag);
        access(to_b, 1'b0, 1'b0, sz, 16'h0, exp, tag);
    endtask

    task automatic load(input bit to_b, input bit bank, input logic [5:0] idx,
                        input logic [63:0] data, input int nbytes, input logic [31:0] len);
        for (int k = 0; k < nbytes; k++) begin
            @(negedge clk);
            if (to_b) begin b_lbw = 1; b_lbank = bank; b_lidx = idx; b_laddr = 3'(k); b_lbyte = data[8*(7-k) +: 8]; end
            else      begin a_lbw = 1; a_lbank = bank; a_lidx = idx; a_laddr = 3'(k); a_lbyte = data[8*(7-k) +: 8]; end
        end
        @(negedge clk);
        a_lbw = 0; b_lbw = 0;
        if (to_b) begin b_llw = 1; b_lbank = bank; b_lidx = idx; b_llen = len; end
        else      begin a_llw = 1; a_lbank = bank; a_lidx = idx; a_llen = len; end
        @(negedge clk);
        a_llw = 0; b_llw = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        checks++;
        if (a_rv !== 1'b0 || b_rv !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset: rd_valid actual=%b/%b expected=0/0", a_rv, b_rv);
        end

        // Signature after reset, then the item is exhausted.
        rd(0, 4'd4, 64'h5AC3960F, "R6 signature read");
        rd(0, 4'd1, 64'h0, "R5 signature exhausted");
        rd(1, 4'd1, 64'h5A, "R6 combined signature first byte");

        load(0, 0, 6'd1,  64'h1122334455000000, 5, 32'd5);
        load(0, 1, 6'd1,  64'hA1A2A30000000000, 3, 32'd3);
        load(0, 0, 6'd63, 64'h7788000000000000, 2, 32'd2);
        load(0, 0, 6'd2,  64'h0102030405060708, 8, 32'd20);
        load(1, 0, 6'd1,  64'h1122334455000000, 5, 32'd5);

        sel(0, 16'h0001);
        rd(0, 4'd2, 64'h1122, "R3 first pair");
        rd(0, 4'd2, 64'h3344, "R3 second pair");
        rd(0, 4'd4, 64'h55000000, "R4 pad right");
        rd(0, 4'd1, 64'h0, "R5 read past end");

        sel(0, 16'h0001);
        rd(0, 4'd8, 64'h1122334455000000, "R1 reselect restarts, R4 eight-byte pad");

        sel(0, 16'h8001);
        rd(0, 4'd3, 64'hA1A2A3, "R2 local bank");
        sel(0, 16'h4001);
        rd(0, 4'd1, 64'h11, "R2 bit14 ignored");
        sel(0, 16'h003F);
        rd(0, 4'd2, 64'h7788, "R2 last valid index");
        sel(0, 16'h0040);
        rd(0, 4'd8, 64'h0, "R2 index at limit invalid");
        sel(0, 16'h3FFF);
        rd(0, 4'd1, 64'h0, "R5 invalid selection");
        sel(0, 16'h0001);
        rd(0, 4'd1, 64'h11, "R1 select after rejected key");

        sel(0, 16'h0002);
        rd(0, 4'd8, 64'h0102030405060708, "R9 long item");
        rd(0, 4'd1, 64'h0, "R9 length clamped");
        sel(0, 16'h0003);
        rd(0, 4'd4, 64'h0, "R5 empty item");

        sel(0, 16'h0001);
        rd(0, 4'd0, 64'h0, "R7 zero width");
        rd(0, 4'd9, 64'h0, "R7 width above eight");
        access(0, 1'b0, 1'b1, 4'd2, 16'h0, 64'h0, "R7 selector reads zero");
        access(0, 1'b1, 1'b0, 4'd1, 16'h00FF, 64'h0, "");
        rd(0, 4'd1, 64'h11, "R7 cursor unchanged by rejected accesses");
        rd(0, 4'd2, 64'h2233, "R7 data write ignored");

        load(0, 0, 6'd1, 64'h0, 0, 32'd2);
        sel(0, 16'h0001);
        rd(0, 4'd4, 64'h11220000, "R9 reloaded length");

        access(1, 1'b1, 1'b0, 4'd2, 16'h0001, 64'h0, "");
        rd(1, 4'd1, 64'h11, "R8 byte read after select");
        rd(1, 4'd2, 64'h0, "R8 two-byte read rejected");
        rd(1, 4'd1, 64'h22, "R8 cursor held");
        access(1, 1'b1, 1'b0, 4'd1, 16'h00EE, 64'h0, "");
        rd(1, 4'd1, 64'h33, "R8 byte write ignored");
        access(1, 1'b1, 1'b0, 4'd4, 16'h0002, 64'h0, "");
        rd(1, 4'd1, 64'h44, "R8 wide write ignored");

        repeat (4) @(negedge clk);
        checks++;
        if (qa.size() != 0 || qb.size() != 0) begin
            errors++;
            $display("FAIL R10 missing responses actual=%0d/%0d expected=0/0", qa.size(), qb.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule